// File: doc/BRIEF.md
# One-Time-Programmable Fuse Controller Register Front End

This block sits between a simple register bus and a separate strobe sequencer that drives a one-time-programmable fuse array. Software addresses a fuse word through a control register, then either triggers a sense, which returns the word's 32-bit value through a result register, or writes a data register to burn bits into that word. Burning is guarded by a 16-bit unlock key that software must write into the control register before every program operation. While a command runs, a busy flag is raised. Malformed or colliding commands set a sticky error flag, and software clears that flag through a clear alias.

The block also holds a bank of shadow registers, one per fuse word. Software can read them and overwrite them directly without touching the array. When a program operation finishes, the shadow register for that word is reloaded with the word's new contents. The sequencer reports those contents with its done pulse.

Top module: `fuse_ctl_regs`

## Requirements
- R1: After reset the control register reads 0, busy is low, no command is issued, and the timing register reads its parameter reset value (default 0x0021_2005).
- R2: The control register reads as {unlock key[31:16], 6'b0, error[9], busy[8], 1'b0, fuse address[6:0]}. A write at word offset 0 loads only the key and address fields. Bits 9 and 8 are read-only there. The fuse address of bank b, word w is b*8+w.
- R3: The set alias (offset 1) ORs the written value into the key and address fields. The clear alias (offset 2) clears the key and address bits written as 1, and writing bit 9 as 1 there clears the error flag without changing the other fields.
- R4: Writing 1 to bit 0 of the sense trigger (offset 4), while idle, issues one command pulse with program=0 and the current address. Busy stays high until the sequencer's done pulse. The sense result (offset 5) then holds the returned data.
- R5: Writing the program-data register (offset 6), while idle and with key 0x3E77 present, issues one command pulse with program=1, the current address and the written data. Busy stays high until done.
- R6: An accepted program operation clears the unlock key field to 0.
- R7: A program-data write without the key 0x3E77 sets the error flag and issues no command.
- R8: A sense or program request while busy is high sets the error flag and issues no command. The running command and its busy flag are unaffected.
- R9: The error flag stays set until it is cleared through the clear alias. Writes to the control register or the set alias do not clear it.
- R10: Shadow register i is read and written at bus word address 0x80+i. A shadow write changes only that register and issues no fuse command.
- R11: When a program operation finishes, the shadow register of the programmed word is loaded with the data returned by the sequencer.
- R12: The timing register (offset 3) is fully readable and writable, and its value drives the timing output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| tmg_o | output | 32 | Timing register contents for the sequencer |
| cmd_valid | output | 1 | One-cycle command pulse to the sequencer |
| cmd_prog | output | 1 | Command type: 1 program, 0 sense |
| cmd_addr | output | 7 | Fuse word address of the command |
| cmd_wdata | output | 32 | Bits to burn for a program command |
| cmd_done | input | 1 | Sequencer finished the current command |
| cmd_rdata | input | 32 | Word contents returned with cmd_done |

## Verification
On every cycle, the assertions check four things: busy never drops without a done pulse, no command pulse appears while a command is running, the error flag is sticky, and every program pulse was preceded by the unlock key and leaves the key cleared. The bench scenarios show the data path. Sensed values, the OR-accumulated contents after programming, the shadow reload, and the independence of shadow overrides from the array can only be seen by comparing register reads against a behavioural fuse array over random sequences of sense, program and override operations.

// File: rtl/fuse_ctl_pkg.sv
package fuse_ctl_pkg;
  localparam logic [15:0] UNLOCK_KEY = 16'h3E77;
  localparam int ERR_BIT  = 9;
  localparam int BUSY_BIT = 8;

  // register selector, value equals word offset inside the register window
  typedef enum logic [2:0] {
    SEL_CTRL  = 3'd0,
    SEL_SET   = 3'd1,
    SEL_CLR   = 3'd2,
    SEL_TMG   = 3'd3,
    SEL_RDCMD = 3'd4,
    SEL_SENSE = 3'd5,
    SEL_PDATA = 3'd6,
    SEL_NONE  = 3'd7
  } reg_sel_e;
endpackage

// File: rtl/fuse_shadow_ram.sv
module fuse_shadow_ram #(
  parameter int AW = 7,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/fuse_cmd_ctl.sv
module fuse_cmd_ctl #(
  parameter int AW = 7,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_sense,
  input  logic          start_prog,
  input  logic          key_ok,
  input  logic          err_clr,
  input  logic [AW-1:0] addr_in,
  input  logic [DW-1:0] data_in,
  input  logic          cmd_done,
  output logic          busy,
  output logic          err,
  output logic          cmd_valid,
  output logic          cmd_prog,
  output logic [AW-1:0] cmd_addr,
  output logic [DW-1:0] cmd_wdata,
  output logic          prog_accept,
  output logic          sense_fin,
  output logic          prog_fin
);
  logic req, accept, bad, fin;

  always_comb begin
    req         = start_sense | start_prog;
    accept      = req && !busy && (start_sense || key_ok);
    bad         = req && !accept;
    prog_accept = accept && start_prog;
    fin         = busy && cmd_done;
    sense_fin   = fin && !cmd_prog;
    prog_fin    = fin && cmd_prog;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      err       <= 1'b0;
      cmd_valid <= 1'b0;
      cmd_prog  <= 1'b0;
      cmd_addr  <= '0;
      cmd_wdata <= '0;
    end else begin
      cmd_valid <= accept;
      if (accept) begin
        busy      <= 1'b1;
        cmd_prog  <= start_prog;
        cmd_addr  <= addr_in;
        cmd_wdata <= data_in;
      end else if (fin) begin
        busy <= 1'b0;
      end
      if (bad)          err <= 1'b1;
      else if (err_clr) err <= 1'b0;
    end
  end

  // R4 busy holds until the sequencer reports done
  p_busy_hold_r4: assert property (@(posedge clk) disable iff (rst)
    busy && !cmd_done |=> busy);
  // R4 busy only falls after a done pulse
  p_busy_fall_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(cmd_done));
  // R8 no new command pulse while one is running
  p_no_issue_busy_r8: assert property (@(posedge clk) disable iff (rst)
    busy && !cmd_done |=> !cmd_valid);
  // R9 error flag is sticky without a clear request
  p_err_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    err && !err_clr |=> err);
endmodule

// File: rtl/fuse_ctl_regs.sv
module fuse_ctl_regs
  import fuse_ctl_pkg::*;
#(
  parameter int          ADDR_W  = 7,
  parameter int          DW      = 32,
  parameter logic [31:0] TMG_RST = 32'h0021_2005
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W:0]   bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              bus_rvalid,
  output logic [31:0]       tmg_o,
  output logic              cmd_valid,
  output logic              cmd_prog,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [DW-1:0]     cmd_wdata,
  input  logic              cmd_done,
  input  logic [DW-1:0]     cmd_rdata
);
  localparam int BUS_AW = ADDR_W + 1;

  reg_sel_e          sel;
  logic              sh_hit;
  logic [15:0]       key_q;
  logic [ADDR_W-1:0] addr_q;
  logic [31:0]       tmg_q;
  logic [DW-1:0]     pdata_q, sense_q, reg_rd_q;
  logic              rd_sh_q;
  logic              busy, err, key_ok, prog_accept, sense_fin, prog_fin;
  logic              start_sense, start_prog, err_clr;
  logic              sh_we;
  logic [ADDR_W-1:0] sh_waddr;
  logic [DW-1:0]     sh_wdata, sh_rdata, ctrl_val;

  always_comb begin
    sh_hit = bus_addr[BUS_AW-1];
    if (sh_hit || (bus_addr[BUS_AW-2:3] != '0)) sel = SEL_NONE;
    else                                         sel = reg_sel_e'(bus_addr[2:0]);
    key_ok      = (key_q == UNLOCK_KEY);
    start_sense = bus_wr && (sel == SEL_RDCMD) && bus_wdata[0];
    start_prog  = bus_wr && (sel == SEL_PDATA);
    err_clr     = bus_wr && (sel == SEL_CLR) && bus_wdata[ERR_BIT];
    ctrl_val    = '0;
    ctrl_val[31:16]    = key_q;
    ctrl_val[ERR_BIT]  = err;
    ctrl_val[BUSY_BIT] = busy;
    ctrl_val[ADDR_W-1:0] = addr_q;
    // a reload from a finished program wins over a same-cycle bus write
    sh_we    = prog_fin || (bus_wr && sh_hit);
    sh_waddr = prog_fin ? cmd_addr  : bus_addr[ADDR_W-1:0];
    sh_wdata = prog_fin ? cmd_rdata : bus_wdata;
  end

  fuse_cmd_ctl #(.AW(ADDR_W), .DW(DW)) u_cmd (
    .clk        (clk),
    .rst        (rst),
    .start_sense(start_sense),
    .start_prog (start_prog),
    .key_ok     (key_ok),
    .err_clr    (err_clr),
    .addr_in    (addr_q),
    .data_in    (bus_wdata),
    .cmd_done   (cmd_done),
    .busy       (busy),
    .err        (err),
    .cmd_valid  (cmd_valid),
    .cmd_prog   (cmd_prog),
    .cmd_addr   (cmd_addr),
    .cmd_wdata  (cmd_wdata),
    .prog_accept(prog_accept),
    .sense_fin  (sense_fin),
    .prog_fin   (prog_fin)
  );

  fuse_shadow_ram #(.AW(ADDR_W), .DW(DW)) u_shadow (
    .clk  (clk),
    .we   (sh_we),
    .waddr(sh_waddr),
    .wdata(sh_wdata),
    .raddr(bus_addr[ADDR_W-1:0]),
    .rdata(sh_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      key_q      <= '0;
      addr_q     <= '0;
      tmg_q      <= TMG_RST;
      pdata_q    <= '0;
      sense_q    <= '0;
      reg_rd_q   <= '0;
      rd_sh_q    <= 1'b0;
      bus_rvalid <= 1'b0;
    end else begin
      if (prog_accept) begin
        key_q <= '0;
      end else if (bus_wr) begin
        case (sel)
          SEL_CTRL: begin
            key_q  <= bus_wdata[31:16];
            addr_q <= bus_wdata[ADDR_W-1:0];
          end
          SEL_SET: begin
            key_q  <= key_q  | bus_wdata[31:16];
            addr_q <= addr_q | bus_wdata[ADDR_W-1:0];
          end
          SEL_CLR: begin
            key_q  <= key_q  & ~bus_wdata[31:16];
            addr_q <= addr_q & ~bus_wdata[ADDR_W-1:0];
          end
          SEL_TMG: tmg_q <= bus_wdata;
          default: ;
        endcase
      end
      if (start_prog) pdata_q <= bus_wdata;
      if (sense_fin)  sense_q <= cmd_rdata;
      bus_rvalid <= bus_rd;
      rd_sh_q    <= bus_rd && sh_hit;
      if (bus_rd) begin
        case (sel)
          SEL_CTRL, SEL_SET, SEL_CLR: reg_rd_q <= ctrl_val;
          SEL_TMG:   reg_rd_q <= tmg_q;
          SEL_SENSE: reg_rd_q <= sense_q;
          SEL_PDATA: reg_rd_q <= pdata_q;
          default:   reg_rd_q <= '0;
        endcase
      end
    end
  end

  assign bus_rdata = rd_sh_q ? sh_rdata : reg_rd_q;
  assign tmg_o     = tmg_q;

  // R5 a program pulse needs the unlock key in the cycle before
  p_prog_key_r5: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && cmd_prog |-> $past(key_q) == UNLOCK_KEY);
  // R6 the key is gone once a program has been issued
  p_key_clear_r6: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && cmd_prog |-> key_q == '0);
  // R7 a program request without key raises error and issues nothing
  p_bad_prog_r7: assert property (@(posedge clk) disable iff (rst)
    start_prog && !key_ok |=> err && !cmd_valid);
endmodule

// File: tb/tb_fuse_ctl_regs.sv
module tb_fuse_ctl_regs;
  localparam int          AW    = 7;
  localparam int          NW    = 1 << AW;
  localparam logic [31:0] TRST  = 32'h0021_2005;
  localparam logic [15:0] KEY   = 16'h3E77;
  localparam logic [7:0]  A_CTRL = 8'h00, A_SET = 8'h01, A_CLR = 8'h02,
                          A_TMG = 8'h03, A_RDC = 8'h04, A_SNS = 8'h05,
                          A_PDT = 8'h06, A_SH = 8'h80;

  logic clk = 1'b0, rst = 1'b1;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata, tmg_o, cmd_wdata;
  logic        bus_rvalid, cmd_valid, cmd_prog;
  logic [AW-1:0] cmd_addr;
  logic        cmd_done = 1'b0;
  logic [31:0] cmd_rdata = '0;

  int checks = 0, fails = 0, cmd_cnt = 0, seq_lat = 1;
  bit finished = 0;
  logic [31:0] fuse_arr [NW];
  logic [31:0] exp_arr  [NW];

  always #2.5 clk = ~clk;

  fuse_ctl_regs dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .tmg_o(tmg_o), .cmd_valid(cmd_valid),
    .cmd_prog(cmd_prog), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .cmd_done(cmd_done), .cmd_rdata(cmd_rdata)
  );

  function automatic logic [31:0] exp_ctrl(logic [15:0] k, bit e, bit b, logic [6:0] a);
    return {k, 6'b0, e, b, 1'b0, a};
  endfunction

  function automatic logic [6:0] fw(int bank, int word);
    return 7'(bank * 8 + word);
  endfunction

  // command monitor
  initial forever begin
    @(negedge clk);
    if (cmd_valid) cmd_cnt++;
  end

  // behavioural strobe sequencer and fuse array
  initial forever begin
    @(negedge clk);
    if (cmd_valid) begin
      logic [6:0]  a;
      logic        p;
      logic [31:0] d;
      a = cmd_addr; p = cmd_prog; d = cmd_wdata;
      repeat (seq_lat - 1) @(negedge clk);
      if (p) fuse_arr[a] = fuse_arr[a] | d;
      cmd_rdata = fuse_arr[a];
      cmd_done  = 1'b1;
      @(negedge clk);
      cmd_done  = 1'b0;
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bw(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic br(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int n = 0; n < 200; n++) begin
      br(A_CTRL, v);
      if (!v[8]) return;
    end
    check("R4 busy timeout", 32'd1, 32'd0);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  initial begin
    logic [31:0] v, d;
    int c0;
    void'($urandom(32'h00C0FFEE));
    for (int i = 0; i < NW; i++) begin
      fuse_arr[i] = $urandom & 32'h0F0F_0F0F;
      exp_arr[i]  = fuse_arr[i];
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    br(A_CTRL, v); check("R1 ctrl", v, 32'h0);
    br(A_TMG, v);  check("R1 timing", v, TRST);
    check("R1 no command", 32'(cmd_cnt), 32'd0);

    // R12 timing register
    bw(A_TMG, 32'hA5C3_1E0F);
    br(A_TMG, v); check("R12 timing readback", v, 32'hA5C3_1E0F);
    check("R12 timing output", tmg_o, 32'hA5C3_1E0F);

    // R2 control field layout, read-only bits ignored
    bw(A_CTRL, {16'h1234, 6'h3F, 1'b1, 1'b1, 1'b1, 7'h55});
    br(A_CTRL, v); check("R2 ctrl fields", v, exp_ctrl(16'h1234, 0, 0, 7'h55));

    // R3 set and clear aliases
    bw(A_SET, {16'h0300, 9'h0, 7'h02});
    br(A_CTRL, v); check("R3 set alias", v, exp_ctrl(16'h1334, 0, 0, 7'h57));
    bw(A_CLR, {16'h1004, 9'h0, 7'h05});
    br(A_CTRL, v); check("R3 clear alias", v, exp_ctrl(16'h0330, 0, 0, 7'h52));

    // R4 sense bank 1 word 5 with long latency, busy visible
    seq_lat = 6;
    c0 = cmd_cnt;
    bw(A_CTRL, {16'h0, 9'h0, fw(1, 5)});
    bw(A_RDC, 32'h1);
    br(A_CTRL, v); check("R4 busy during sense", v, exp_ctrl(0, 0, 1, fw(1, 5)));
    wait_idle();
    br(A_SNS, v); check("R4 sense data", v, exp_arr[fw(1, 5)]);
    check("R4 one command", 32'(cmd_cnt - c0), 32'd1);

    // R4 trigger with bit0 clear does nothing
    c0 = cmd_cnt;
    bw(A_RDC, 32'hFFFF_FFFE);
    br(A_CTRL, v); check("R4 bit0 clear ignored", v, exp_ctrl(0, 0, 0, fw(1, 5)));
    check("R4 bit0 clear no command", 32'(cmd_cnt - c0), 32'd0);

    // R5 R6 R11 program bank 2 word 3
    seq_lat = 3;
    c0 = cmd_cnt;
    d = 32'h8421_F00D;
    bw(A_CTRL, {KEY, 9'h0, fw(2, 3)});
    bw(A_PDT, d);
    br(A_CTRL, v); check("R6 key cleared", v, exp_ctrl(0, 0, v[8], fw(2, 3)));
    wait_idle();
    exp_arr[fw(2, 3)] = exp_arr[fw(2, 3)] | d;
    check("R5 program command", 32'(cmd_cnt - c0), 32'd1);
    check("R5 array ORed", fuse_arr[fw(2, 3)], exp_arr[fw(2, 3)]);
    br(A_SH + 8'(fw(2, 3)), v); check("R11 shadow reload", v, exp_arr[fw(2, 3)]);

    // R7 second program without fresh key
    c0 = cmd_cnt;
    bw(A_PDT, 32'hFFFF_FFFF);
    br(A_CTRL, v); check("R7 error no key", v, exp_ctrl(0, 1, 0, fw(2, 3)));
    check("R7 no command", 32'(cmd_cnt - c0), 32'd0);
    check("R7 array untouched", fuse_arr[fw(2, 3)], exp_arr[fw(2, 3)]);

    // R9 error survives ctrl and set writes
    bw(A_CTRL, {16'h0, 9'h0, 7'h11});
    bw(A_SET, 32'h0000_0200);
    br(A_CTRL, v); check("R9 error sticky", v, exp_ctrl(0, 1, 0, 7'h11));
    bw(A_CLR, 32'h0000_0200);
    br(A_CTRL, v); check("R3 clear error only", v, exp_ctrl(0, 0, 0, 7'h11));

    // R8 command while busy
    seq_lat = 10;
    c0 = cmd_cnt;
    bw(A_RDC, 32'h1);
    bw(A_RDC, 32'h1);
    br(A_CTRL, v); check("R8 error and still busy", v, exp_ctrl(0, 1, 1, 7'h11));
    wait_idle();
    check("R8 single command", 32'(cmd_cnt - c0), 32'd1);
    br(A_SNS, v); check("R8 first sense completes", v, exp_arr[7'h11]);
    bw(A_CLR, 32'h0000_0200);

    // R10 shadow override does not reach the array
    seq_lat = 2;
    c0 = cmd_cnt;
    bw(A_SH + 8'd5, 32'hDEAD_BEEF);
    br(A_SH + 8'd5, v); check("R10 shadow readback", v, 32'hDEAD_BEEF);
    check("R10 override no command", 32'(cmd_cnt - c0), 32'd0);
    bw(A_CTRL, 32'd5);
    bw(A_RDC, 32'h1);
    wait_idle();
    br(A_SNS, v); check("R10 array unchanged", v, exp_arr[5]);

    // random mix
    for (int it = 0; it < 60; it++) begin
      int w, op;
      w  = $urandom_range(0, NW - 1);
      op = $urandom_range(0, 2);
      seq_lat = $urandom_range(1, 6);
      d = $urandom;
      if (op == 0) begin
        bw(A_CTRL, 32'(w));
        bw(A_RDC, 32'h1);
        wait_idle();
        br(A_SNS, v); check("R4 random sense", v, exp_arr[w]);
      end else if (op == 1) begin
        bw(A_CTRL, {KEY, 9'h0, 7'(w)});
        bw(A_PDT, d);
        wait_idle();
        exp_arr[w] = exp_arr[w] | d;
        br(A_SH + 8'(w), v); check("R11 random reload", v, exp_arr[w]);
      end else begin
        bw(A_SH + 8'(w), d);
        br(A_SH + 8'(w), v); check("R10 random override", v, d);
      end
      br(A_CTRL, v); check("R9 no spurious error", 32'(v[9]), 32'd0);
    end

    summary();
  end
endmodule